// File: doc/BRIEF.md
# Row Refresh Scheduler

This block decides when a DRAM bank gets refreshed so that every row is recharged once in each retention window. The window is a fixed count of clock cycles. The bank's rows are split into equal row groups, and one refresh command covers one group. A mode input picks one of two schedules. In distributed mode, one command falls due at a steady interval, so the group commands are spaced evenly across the window. In burst mode, all groups are refreshed back to back once per window.

When a command falls due, the block raises a request to the command arbiter and holds it until a grant comes back. If grants are late, due commands pile up in an owed counter. Once the counter is full, the block flags the request as urgent. After a grant, the block drives a busy output that stops the controller from issuing reads or writes to the bank. Each row group keeps busy high for a programmable number of cycles. A group counter names the group being refreshed and wraps at the end of the bank.

A mode change only takes effect at a window boundary, so one window never mixes the two schedules.

Top module: `refresh_scheduler`

## Requirements
- R1: While reset is held, the block outputs: request low, urgent low, busy low, row group 0, owed count 0. The active mode after reset is distributed.
- R2: The mode input uses 0 for distributed and 1 for burst. In distributed mode, one command becomes owed every INTERVAL = WINDOW_CYCLES / (NUM_ROWS / ROWS_PER_CMD) cycles. The first one becomes owed on the INTERVAL-th rising edge after reset is released.
- R3: The request output is high exactly when the owed count is non-zero and busy is low. Once raised, it stays high until a grant is sampled with it.
- R4: A grant sampled together with the request takes one owed command. Busy goes high on the next cycle. Each row group holds busy for trfc_i cycles, and a trfc_i of 0 counts as 1.
- R5: The request is never high while busy is high.
- R6: The row group output advances by one when each group's busy time ends. It wraps from NUM_GROUPS-1 to 0, and it changes at no other time.
- R7: The owed count saturates at MAX_POSTPONE+1, so further due commands are dropped. Urgent is high exactly while the count sits at that limit, and it stays high until a grant.
- R8: In burst mode, one command becomes owed on the first cycle of each window. Its grant keeps busy high for NUM_GROUPS * trfc_i consecutive cycles and walks the row group once around the bank.
- R9: The mode input is sampled only on the last cycle of a window. A change in mid-window leaves the current window's schedule untouched.
- R10: The number of groups a granted command refreshes is set by the mode active when the grant is taken: 1 in distributed mode, NUM_GROUPS in burst mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_mode_i | input | 1 | Requested mode: 0 distributed, 1 burst |
| trfc_i | input | TRFC_W | Busy cycles for each row group |
| ref_gnt_i | input | 1 | Grant from the command arbiter |
| ref_req_o | output | 1 | Refresh request to the arbiter |
| ref_urgent_o | output | 1 | Owed count is at its limit |
| bank_busy_o | output | 1 | Bank is blocked for refresh |
| row_grp_o | output | GRP_W | Row group being (or next to be) refreshed |
| pend_cnt_o | output | PEND_W | Number of owed refresh commands |

## Verification
The bench holds the grant low for longer than the postponement allowance. This shows that the owed count saturates instead of wrapping and that urgent rises at the limit. A counter that wrapped would drop urgent, or lose all owed work at once. The bench also switches the mode in the middle of a window and checks that the distributed cadence goes on until the boundary. A design that latched the mode early would skip the interval tick, or start a burst too soon.

The burst is timed end to end, and the row group must come back to where it began. A wrong group count or a wrap error would show up as the wrong length or the wrong end group. Finally, a zero refresh time must still give a one-cycle busy pulse, not a stuck or missing one.

// File: rtl/rs_pkg.sv
package rs_pkg;
    typedef enum logic {
        MODE_DIST  = 1'b0,
        MODE_BURST = 1'b1
    } rs_mode_e;
endpackage

// File: rtl/rs_timer.sv
// Window and interval counters, with the window-aligned mode latch.
module rs_timer #(
    parameter int WINDOW_CYCLES = 32768,
    parameter int INTERVAL      = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_i,
    output rs_pkg::rs_mode_e mode_o,
    output logic            tick_o
);
    import rs_pkg::*;

    localparam int WIN_W = (WINDOW_CYCLES > 2) ? $clog2(WINDOW_CYCLES) : 1;
    localparam int IVL_W = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;

    typedef struct packed {
        logic [WIN_W-1:0] win;
        logic [IVL_W-1:0] ivl;
        rs_mode_e         mode;
    } tmr_t;

    tmr_t s_q, s_d;
    logic win_end;

    always_comb begin
        s_d     = s_q;
        win_end = (s_q.win == WIN_W'(WINDOW_CYCLES - 1));
        s_d.win = win_end ? '0 : s_q.win + 1'b1;
        if (win_end || s_q.ivl == IVL_W'(INTERVAL - 1)) begin
            s_d.ivl = '0;
        end else begin
            s_d.ivl = s_q.ivl + 1'b1;
        end
        if (win_end) begin
            s_d.mode = mode_i ? MODE_BURST : MODE_DIST;
        end
        if (s_q.mode == MODE_DIST) begin
            tick_o = (s_q.ivl == IVL_W'(INTERVAL - 1));
        end else begin
            tick_o = (s_q.win == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{win: '0, ivl: '0, mode: MODE_DIST};
        end else begin
            s_q <= s_d;
        end
    end

    assign mode_o = s_q.mode;
endmodule

// File: rtl/rs_engine.sv
// Owed-command counter, grant handshake, busy timing and row-group walk.
module rs_engine #(
    parameter int NUM_GROUPS = 1024,
    parameter int PEND_MAX   = 9,
    parameter int TRFC_W     = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_i,
    input  rs_pkg::rs_mode_e      mode_i,
    input  logic [TRFC_W-1:0]     trfc_i,
    input  logic                  gnt_i,
    output logic                  req_o,
    output logic                  urgent_o,
    output logic                  busy_o,
    output logic [$clog2(NUM_GROUPS)-1:0]   grp_o,
    output logic [$clog2(PEND_MAX+1)-1:0]   pend_o
);
    import rs_pkg::*;

    localparam int GRP_W  = $clog2(NUM_GROUPS);
    localparam int PEND_W = $clog2(PEND_MAX + 1);
    localparam int GL_W   = $clog2(NUM_GROUPS + 1);

    typedef struct packed {
        logic [PEND_W-1:0] pend;
        logic              busy;
        logic [TRFC_W-1:0] tcnt;
        logic [GL_W-1:0]   gleft;
        logic [GRP_W-1:0]  grp;
    } eng_t;

    eng_t s_q, s_d;
    logic accept;
    logic [TRFC_W-1:0] trfc_eff;

    always_comb begin
        s_d      = s_q;
        req_o    = (s_q.pend != '0) && !s_q.busy;
        accept   = req_o && gnt_i;
        trfc_eff = (trfc_i == '0) ? TRFC_W'(1) : trfc_i;

        if (accept) begin
            s_d.pend = s_d.pend - 1'b1;
        end
        if (tick_i && s_d.pend != PEND_W'(PEND_MAX)) begin
            s_d.pend = s_d.pend + 1'b1;
        end

        if (accept) begin
            s_d.busy  = 1'b1;
            s_d.tcnt  = trfc_eff;
            s_d.gleft = (mode_i == MODE_BURST) ? GL_W'(NUM_GROUPS) : GL_W'(1);
        end else if (s_q.busy) begin
            if (s_q.tcnt == TRFC_W'(1)) begin
                s_d.grp = (s_q.grp == GRP_W'(NUM_GROUPS - 1)) ? '0 : s_q.grp + 1'b1;
                if (s_q.gleft == GL_W'(1)) begin
                    s_d.busy  = 1'b0;
                    s_d.gleft = '0;
                end else begin
                    s_d.gleft = s_q.gleft - 1'b1;
                    s_d.tcnt  = trfc_eff;
                end
            end else begin
                s_d.tcnt = s_q.tcnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign urgent_o = (s_q.pend == PEND_W'(PEND_MAX));
    assign busy_o   = s_q.busy;
    assign grp_o    = s_q.grp;
    assign pend_o   = s_q.pend;
endmodule

// File: rtl/refresh_scheduler.sv
module refresh_scheduler #(
    parameter int WINDOW_CYCLES = 32768,
    parameter int NUM_ROWS      = 8192,
    parameter int ROWS_PER_CMD  = 8,
    parameter int MAX_POSTPONE  = 8,
    parameter int TRFC_W        = 8,
    localparam int NUM_GROUPS   = NUM_ROWS / ROWS_PER_CMD,
    localparam int INTERVAL     = WINDOW_CYCLES / NUM_GROUPS,
    localparam int PEND_MAX     = MAX_POSTPONE + 1,
    localparam int GRP_W        = $clog2(NUM_GROUPS),
    localparam int PEND_W       = $clog2(PEND_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_mode_i,
    input  logic [TRFC_W-1:0] trfc_i,
    input  logic              ref_gnt_i,
    output logic              ref_req_o,
    output logic              ref_urgent_o,
    output logic              bank_busy_o,
    output logic [GRP_W-1:0]  row_grp_o,
    output logic [PEND_W-1:0] pend_cnt_o
);
    rs_pkg::rs_mode_e act_mode;
    logic             due_tick;

    rs_timer #(
        .WINDOW_CYCLES(WINDOW_CYCLES),
        .INTERVAL     (INTERVAL)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .mode_i(burst_mode_i),
        .mode_o(act_mode),
        .tick_o(due_tick)
    );

    rs_engine #(
        .NUM_GROUPS(NUM_GROUPS),
        .PEND_MAX  (PEND_MAX),
        .TRFC_W    (TRFC_W)
    ) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (due_tick),
        .mode_i  (act_mode),
        .trfc_i  (trfc_i),
        .gnt_i   (ref_gnt_i),
        .req_o   (ref_req_o),
        .urgent_o(ref_urgent_o),
        .busy_o  (bank_busy_o),
        .grp_o   (row_grp_o),
        .pend_o  (pend_cnt_o)
    );
endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
    parameter int NUM_GROUPS = 4,
    parameter int PEND_MAX   = 9,
    parameter int GRP_W      = 2,
    parameter int PEND_W     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              gnt,
    input logic              req,
    input logic              busy,
    input logic              urgent,
    input logic [GRP_W-1:0]  grp,
    input logic [PEND_W-1:0] pend
);
    assert_no_req_when_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req);

    assert_busy_from_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req && gnt));

    assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !gnt) |=> req);

    assert_pend_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pend <= PEND_W'(PEND_MAX));

    assert_urgent_until_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (urgent && !(req && gnt)) |=> urgent);

    assert_grp_moves_in_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(grp) |-> $past(busy));

    assert_grp_steps_by_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(grp) |-> (grp == (($past(grp) == GRP_W'(NUM_GROUPS - 1)) ? '0 : $past(grp) + 1'b1)));
endmodule

bind refresh_scheduler rs_checker #(
    .NUM_GROUPS(NUM_GROUPS),
    .PEND_MAX  (PEND_MAX),
    .GRP_W     (GRP_W),
    .PEND_W    (PEND_W)
) u_rs_checker (
    .clk   (clk),
    .rst_n (rst_n),
    .gnt   (ref_gnt_i),
    .req   (ref_req_o),
    .busy  (bank_busy_o),
    .urgent(ref_urgent_o),
    .grp   (row_grp_o),
    .pend  (pend_cnt_o)
);

// File: tb/test_refresh_scheduler.sv
module test_refresh_scheduler;
    localparam int CLK_PERIOD = 10;
    localparam int WIN   = 256;
    localparam int ROWS  = 16;
    localparam int RPC   = 2;
    localparam int MAXP  = 8;
    localparam int G     = ROWS / RPC;
    localparam int IVL   = WIN / G;
    localparam int PMAX  = MAXP + 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       burst_mode_i = 1'b0;
    logic [7:0] trfc_i = 8'd5;
    logic       ref_gnt_i = 1'b0;
    logic       ref_req_o, ref_urgent_o, bank_busy_o;
    logic [$clog2(G)-1:0]      row_grp_o;
    logic [$clog2(PMAX+1)-1:0] pend_cnt_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    refresh_scheduler #(
        .WINDOW_CYCLES(WIN),
        .NUM_ROWS     (ROWS),
        .ROWS_PER_CMD (RPC),
        .MAX_POSTPONE (MAXP),
        .TRFC_W       (8)
    ) i_refresh_scheduler (
        .clk         (clk),
        .rst_n       (rst_n),
        .burst_mode_i(burst_mode_i),
        .trfc_i      (trfc_i),
        .ref_gnt_i   (ref_gnt_i),
        .ref_req_o   (ref_req_o),
        .ref_urgent_o(ref_urgent_o),
        .bank_busy_o (bank_busy_o),
        .row_grp_o   (row_grp_o),
        .pend_cnt_o  (pend_cnt_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, driven by the cycle count since reset
    int  m_n = 0;
    int  m_pend = 0;
    int  m_left = 0;
    int  m_grp = 0;
    int  m_T = 1;
    bit  m_burst = 0;
    int  pos;
    bit  tck, acc;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_n = 0; m_pend = 0; m_left = 0; m_grp = 0; m_T = 1; m_burst = 0;
        end else begin
            pos = m_n % WIN;
            tck = m_burst ? (pos == 0) : ((pos % IVL) == IVL - 1);
            acc = (m_pend > 0) && (m_left == 0) && ref_gnt_i;
            if (m_left > 0) begin
                m_left = m_left - 1;
                if (m_left % m_T == 0) m_grp = (m_grp + 1) % G;
            end
            if (acc) begin
                m_T = (trfc_i == 0) ? 1 : int'(trfc_i);
                m_left = m_T * (m_burst ? G : 1);   // R10 length set at grant
            end
            m_pend = m_pend - int'(acc) + int'(tck);
            if (m_pend > PMAX) m_pend = PMAX;
            if (pos == WIN - 1) m_burst = burst_mode_i;   // R9
            m_n = m_n + 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(ref_req_o == ((m_pend > 0) && (m_left == 0)), "R3/R5 req",
                int'(ref_req_o), int'((m_pend > 0) && (m_left == 0)));
            chk(bank_busy_o == (m_left > 0), "R4/R8/R10 busy",
                int'(bank_busy_o), int'(m_left > 0));
            chk(int'(row_grp_o) == m_grp, "R6 row group", int'(row_grp_o), m_grp);
            chk(int'(pend_cnt_o) == m_pend, "R2/R7 owed count", int'(pend_cnt_o), m_pend);
            chk(ref_urgent_o == (m_pend == PMAX), "R7 urgent",
                int'(ref_urgent_o), int'(m_pend == PMAX));
        end
    end

    initial begin : main
        int p0, g0, cnt;
        repeat (3) @(negedge clk);
        chk(!ref_req_o && !bank_busy_o && !ref_urgent_o, "R1 reset controls", 
            int'({ref_req_o, bank_busy_o, ref_urgent_o}), 0);
        chk(row_grp_o == '0 && pend_cnt_o == '0, "R1 reset counters",
            int'(row_grp_o) + int'(pend_cnt_o), 0);
        rst_n = 1'b1;

        repeat (IVL - 1) @(negedge clk);
        chk(pend_cnt_o == '0, "R2 nothing owed before interval", int'(pend_cnt_o), 0);
        @(negedge clk);
        chk(int'(pend_cnt_o) == 1 && ref_req_o, "R2 owed after interval", int'(pend_cnt_o), 1);

        ref_gnt_i = 1'b1;
        repeat (400) @(negedge clk);

        ref_gnt_i = 1'b0;
        repeat (11 * IVL) @(negedge clk);
        chk(int'(pend_cnt_o) == PMAX, "R7 owed count saturates", int'(pend_cnt_o), PMAX);
        chk(ref_urgent_o == 1'b1, "R7 urgent at limit", int'(ref_urgent_o), 1);

        ref_gnt_i = 1'b1;
        repeat (200) @(negedge clk);

        while (m_n % WIN != 10) @(negedge clk);
        ref_gnt_i = 1'b0;
        burst_mode_i = 1'b1;
        p0 = int'(pend_cnt_o);
        repeat (IVL) @(negedge clk);
        chk(int'(pend_cnt_o) == p0 + 1, "R9 mid-window switch keeps cadence",
            int'(pend_cnt_o), p0 + 1);
        ref_gnt_i = 1'b1;

        while (m_n % WIN != 1) @(negedge clk);
        g0 = int'(row_grp_o);
        while (!bank_busy_o) @(negedge clk);
        cnt = 0;
        while (bank_busy_o) begin
            cnt++;
            @(negedge clk);
        end
        chk(cnt == G * 5, "R8 burst busy length", cnt, G * 5);
        chk(int'(row_grp_o) == g0, "R8 burst walks whole bank", int'(row_grp_o), g0);

        burst_mode_i = 1'b0;
        while (m_n % WIN != 5) @(negedge clk);
        trfc_i = 8'd0;
        while (!bank_busy_o) @(negedge clk);
        cnt = 0;
        while (bank_busy_o) begin
            cnt++;
            @(negedge clk);
        end
        chk(cnt == 1, "R4 zero refresh time gives one cycle", cnt, 1);

        repeat (300) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule